// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the control section of a 100-tap digitally controlled potentiometer. It takes a three-wire interface: an active-low select, a direction level and an active-low step strobe. It keeps a saturating tap position counter and drives a registered one-hot tap select vector, with one line per tap. All three wires are asynchronous. Each one passes through a two-flop synchronizer, and edges are detected in the system clock domain. No wire is used as a clock.

When select is released while the strobe is high, the block commits the current position to an emulated non-volatile register. The commit takes a timed write phase of `STORE_CYCLES` clocks, during which `busy` is high. When the write ends, the block enters a standby state that lasts until it is selected again. Two resets exist. A warm reset models a power-up: the counter recalls the saved position and the saved value is kept. A cold reset models the first power-on: the saved value itself is cleared to zero.

Top module: `tap_position_ctrl`

## Requirements
- R1: The position always stays in the range 0 to 99. Stepping up at 99 holds 99, and stepping down at 0 holds 0; the counter never wraps.
- R2: `tap_sel` has exactly one bit set, and the index of that bit equals `position`.
- R3: Each falling edge of `step_n` while selected moves the position by exactly one. `dir_up`=1 moves it up and `dir_up`=0 moves it down. The new value appears on the outputs after the second rising clock edge following the edge that first samples the falling strobe.
- R4: Strobe edges while `sel_n` is high leave the position unchanged.
- R5: A rising edge of `sel_n` while `step_n` is high starts a store of the current position. `busy` is then high for exactly `STORE_CYCLES` cycles.
- R6: A rising edge of `sel_n` while `step_n` is low starts no store. `busy` stays low and the saved value is unchanged.
- R7: While `busy` is high, strobe and select activity are ignored: the position does not move and no new store starts.
- R8: `standby` goes high when a store completes and goes low once the block is selected with `busy` low. `standby` and `busy` are never high together.
- R9: A warm reset (`rst`) loads the position from the saved value and keeps the saved value.
- R10: A cold reset (`cold_rst`) sets both the saved value and the position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous warm reset, active high; recalls the saved position |
| cold_rst | input | 1 | Synchronous cold reset, active high; clears the saved value |
| sel_n | input | 1 | Active-low select, asynchronous |
| dir_up | input | 1 | Step direction, 1 = up; asynchronous |
| step_n | input | 1 | Step strobe, acts on its falling edge; asynchronous |
| tap_sel | output | TAPS | Registered one-hot tap select |
| position | output | PW | Registered tap position |
| busy | output | 1 | High during the timed store phase |
| standby | output | 1 | High after a completed store until the block is selected again |

## Verification
The hardest situation to reach is interface traffic that arrives inside the store window. This traffic includes a select that falls and rises again, and strobe pulses with select low. The stimulus releases select with the strobe high, then immediately toggles select and pulses the strobe within the `STORE_CYCLES` window. The position and the saved value must stay untouched, and no second store may follow. The saved value is otherwise hidden, so the bench brings it out through a warm reset. It does this after a release with the strobe low, which must not have overwritten the saved value.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;
  localparam int TAPS_DEF  = 100;
  // Roughly 20 ms worth of clocks at 1 MHz; set for the real clock.
  localparam int STORE_DEF = 20000;

  // bit order of the synchronized interface bundle
  localparam int IX_DIR  = 0;
  localparam int IX_STEP = 1;
  localparam int IX_SEL  = 2;
  localparam int NWIRES  = 3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITING = 2'd1,
    ST_STANDBY = 2'd2
  } store_state_t;
endpackage

// File: rtl/wire_sync.sv
module wire_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign fall[g] = prev_q[g] & ~sync_q[g];
      assign rise[g] = ~prev_q[g] & sync_q[g];
    end
  endgenerate

  assign lvl = sync_q;
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int TAPS = 100,
  parameter int PW   = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          rst,
  input  logic [PW-1:0] recall_val,
  input  logic          step_en,
  input  logic          up,
  output logic [PW-1:0] pos_d,
  output logic [PW-1:0] pos_q
);
  localparam logic [PW-1:0] TOP = PW'(TAPS - 1);

  always_comb begin
    pos_d = pos_q;
    if (cold_rst)
      pos_d = '0;
    else if (rst)
      pos_d = recall_val;
    else if (step_en) begin
      if (up)
        pos_d = (pos_q >= TOP) ? TOP : pos_q + 1'b1;
      else
        pos_d = (pos_q == '0) ? '0 : pos_q - 1'b1;
    end
  end

  always_ff @(posedge clk) pos_q <= pos_d;
endmodule

// File: rtl/nv_store.sv
module nv_store
  import tapctl_pkg::*;
#(
  parameter int PW           = 7,
  parameter int STORE_CYCLES = 20000,
  parameter int CW           = $clog2(STORE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          cold_rst,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] wr_val,
  input  logic          selected,
  output logic [PW-1:0] nv_q,
  output logic          busy,
  output logic          standby
);
  store_state_t  st_q;
  logic [CW-1:0] left_q;
  logic [PW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      nv_q   <= '0;
      st_q   <= ST_IDLE;
      left_q <= '0;
      pend_q <= '0;
    end else if (rst) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
    end else begin
      case (st_q)
        ST_WRITING: begin
          if (left_q == CW'(1)) begin
            nv_q <= pend_q;
            st_q <= ST_STANDBY;
          end
          left_q <= left_q - 1'b1;
        end
        default: begin
          if (start) begin
            st_q   <= ST_WRITING;
            left_q <= CW'(STORE_CYCLES);
            pend_q <= wr_val;
          end else if (selected)
            st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy    = (st_q == ST_WRITING);
  assign standby = (st_q == ST_STANDBY);
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
  parameter int TAPS = 100,
  parameter int PW   = $clog2(TAPS)
) (
  input  logic [PW-1:0]   pos,
  output logic [TAPS-1:0] onehot
);
  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_tap
      assign onehot[g] = (pos == PW'(g));
    end
  endgenerate
endmodule

// File: rtl/tap_position_ctrl.sv
module tap_position_ctrl
  import tapctl_pkg::*;
#(
  parameter int TAPS         = TAPS_DEF,
  parameter int STORE_CYCLES = STORE_DEF,
  parameter int PW           = $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cold_rst,
  input  logic            sel_n,
  input  logic            dir_up,
  input  logic            step_n,
  output logic [TAPS-1:0] tap_sel,
  output logic [PW-1:0]   position,
  output logic            busy,
  output logic            standby
);
  logic [NWIRES-1:0] raw, lvl, fall, rise;
  logic [PW-1:0]     pos_d, pos_q, nv_val;
  logic [TAPS-1:0]   dec_d;
  logic              selected, step_en, store_go, sync_rst;

  assign raw[IX_DIR]  = dir_up;
  assign raw[IX_STEP] = step_n;
  assign raw[IX_SEL]  = sel_n;
  assign sync_rst     = rst | cold_rst;

  wire_sync #(.W(NWIRES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(sync_rst), .din(raw),
    .lvl(lvl), .fall(fall), .rise(rise)
  );

  assign selected = ~lvl[IX_SEL];
  assign step_en  = selected & fall[IX_STEP] & ~busy;
  assign store_go = rise[IX_SEL] & lvl[IX_STEP] & ~busy;

  step_counter #(.TAPS(TAPS), .PW(PW)) u_cnt (
    .clk(clk), .cold_rst(cold_rst), .rst(rst), .recall_val(nv_val),
    .step_en(step_en), .up(lvl[IX_DIR]), .pos_d(pos_d), .pos_q(pos_q)
  );

  nv_store #(.PW(PW), .STORE_CYCLES(STORE_CYCLES)) u_nv (
    .clk(clk), .cold_rst(cold_rst), .rst(rst), .start(store_go),
    .wr_val(pos_q), .selected(selected), .nv_q(nv_val),
    .busy(busy), .standby(standby)
  );

  tap_decoder #(.TAPS(TAPS), .PW(PW)) u_dec (.pos(pos_d), .onehot(dec_d));

  always_ff @(posedge clk) tap_sel <= dec_d;

  assign position = pos_q;
endmodule

// File: rtl/tap_position_chk.sv
module tap_position_chk #(
  parameter int TAPS = 100,
  parameter int PW   = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            cold_rst,
  input logic [TAPS-1:0] tap_sel,
  input logic [PW-1:0]   position,
  input logic            busy,
  input logic            standby
);
  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst || cold_rst)
    position <= PW'(TAPS - 1)); // R1
  AST_ONE_TAP: assert property (@(posedge clk) disable iff (rst || cold_rst)
    $countones(tap_sel) == 1 && tap_sel[position]); // R2
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst || cold_rst)
    (!$past(rst) && !$past(cold_rst)) |->
      (position == $past(position) || position == $past(position) + 1'b1
       || position + 1'b1 == $past(position))); // R3
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst || cold_rst)
    busy |=> $stable(position)); // R7
  AST_STANDBY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst || cold_rst)
    !(busy && standby)); // R8
endmodule

bind tap_position_ctrl tap_position_chk #(.TAPS(TAPS), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cold_rst(cold_rst), .tap_sel(tap_sel),
  .position(position), .busy(busy), .standby(standby)
);

// File: tb/sim_tap_position_ctrl.sv
module sim_tap_position_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 100;
  localparam int PW = 7;
  localparam int STORE = 40;

  logic clk = 0, rst = 1, cold_rst = 1, sel_n = 1, dir_up = 0, step_n = 1;
  logic [TAPS-1:0] tap_sel;
  logic [PW-1:0] position;
  logic busy, standby;
  int tests = 0, fails = 0, cyc = 0;

  tap_position_ctrl #(.TAPS(TAPS), .STORE_CYCLES(STORE)) u0 (
    .clk(clk), .rst(rst), .cold_rst(cold_rst), .sel_n(sel_n), .dir_up(dir_up),
    .step_n(step_n), .tap_sel(tap_sel), .position(position), .busy(busy),
    .standby(standby));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int hs[4], hp[4], hd[4];
  int m_pos = 0, m_nv = 0, m_busy = 0, m_left = 0, m_pend = 0, m_stby = 0;
  bit started = 0;

  always @(posedge clk) begin
    started = 1;
    if (cold_rst || rst) begin
      for (int i = 0; i < 4; i++) begin hs[i] = 1; hp[i] = 1; hd[i] = 0; end
      if (cold_rst) begin m_nv = 0; m_pos = 0; end else m_pos = m_nv;
      m_busy = 0; m_stby = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hp[i] = hp[i-1]; hd[i] = hd[i-1]; end
      hs[0] = sel_n; hp[0] = step_n; hd[0] = dir_up;
      if (m_busy != 0) begin
        if (m_left == 1) begin m_busy = 0; m_nv = m_pend; m_stby = 1; end
        m_left--;
      end else begin
        if (hs[2] == 0) begin
          m_stby = 0;
          if (hp[3] == 1 && hp[2] == 0) begin
            if (hd[2] == 1) m_pos = (m_pos >= 99) ? 99 : m_pos + 1;
            else m_pos = (m_pos == 0) ? 0 : m_pos - 1;
          end
        end else if (hs[3] == 0 && hp[2] == 1) begin
          m_busy = 1; m_left = STORE; m_pend = m_pos;
        end
      end
    end
  end

  task automatic chk(input int got, input int exp, input string req);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      logic [TAPS-1:0] e;
      e = '0; e[m_pos] = 1'b1;
      chk(position, m_pos, "R3 position vs model");
      tests++;
      if (tap_sel !== e) begin
        fails++;
        $display("FAIL R2 tap_sel got=%h exp=%h", tap_sel, e);
      end
      chk(busy, m_busy, "R5 busy vs model");
      chk(standby, m_stby, "R8 standby vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 30000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit up, input int n);
    for (int k = 0; k < n; k++) begin
      dir_up = up; idle(2);
      step_n = 0; idle(4);
      step_n = 1; idle(4);
    end
    idle(4);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 500 && busy; k++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 0; cold_rst = 0; idle(2);
    chk(position, 0, "R10 cold reset position");
    chk(busy, 0, "R10 cold reset busy");
    sel_n = 0; idle(4);
    pulse(1, 5);  chk(position, 5, "R3 up steps");
    pulse(0, 2);  chk(position, 3, "R3 down steps");
    pulse(0, 6);  chk(position, 0, "R1 floor at 0");
    pulse(1, 105); chk(position, 99, "R1 ceiling at 99");
    pulse(0, 10); chk(position, 89, "R3 down from top");
    sel_n = 1; idle(4);
    chk(busy, 1, "R5 store started");
    sel_n = 0; idle(3);
    dir_up = 0; step_n = 0; idle(4); step_n = 1; idle(4);
    step_n = 0; idle(4); step_n = 1; idle(3);
    sel_n = 1; idle(3);
    chk(position, 89, "R7 activity while busy ignored");
    chk(busy, 1, "R7 still busy");
    wait_idle(); idle(3);
    chk(standby, 1, "R8 standby after store");
    chk(busy, 0, "R7 no second store");
    sel_n = 0; idle(5);
    chk(standby, 0, "R8 standby cleared on select");
    pulse(1, 3); chk(position, 92, "R3 up after store");
    step_n = 0; idle(5);
    sel_n = 1; idle(5);
    step_n = 1; idle(5);
    chk(position, 93, "R6 release with strobe low");
    chk(busy, 0, "R6 no store started");
    rst = 1; idle(1); rst = 0; idle(2);
    chk(position, 89, "R6 R9 recall of saved value");
    pulse(1, 4);
    chk(position, 89, "R4 deselected strobes ignored");
    cold_rst = 1; idle(1); cold_rst = 0; idle(2);
    chk(position, 0, "R10 cold reset clears");
    rst = 1; idle(1); rst = 0; idle(2);
    chk(position, 0, "R10 saved value cleared");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule